// File: doc/BRIEF.md
# Zero-turnaround pipelined burst SRAM

This block is a synthesizable model of a synchronous static RAM whose data bus never needs an idle cycle when traffic switches between reads and writes. A read presents its data one clock after the command is taken. A write takes its data two clocks after the command. Because of this offset, a write command can follow a read command, and a read can follow a write, on consecutive edges. Writes still waiting for their data sit in a two-stage pending pipeline. A read that targets one of those words receives the newly arriving bytes in place of the stale array contents.

Every command is taken on a rising edge while the active-low clock enable is asserted. With the advance input low, the command loads a new address. With advance high, it continues the current four-beat burst from an internally generated address, in either linear or interleaved order. A sleep request freezes the block two cycles after it is raised. Normal operation resumes two cycles after the request is dropped, and memory and pipeline contents are kept. The data bus is split into an input word, an output word and an output-drive flag.

Top module: `pipe_burst_sram`

## Requirements
- R1: After a synchronous reset, dout is zero, dout_en is low, no access is pending and no burst is active.
- R2: A read command (cen_n=0, adv=0, we_n=1) accepted at edge k updates dout at edge k+1, and dout_en is then high while oe_n is low.
- R3: oe_n is not registered: while it is high, dout_en is low in the same cycle, and dout keeps its value.
- R4: A write command (cen_n=0, adv=0, we_n=0) accepted at edge k stores din as sampled at the second accepted edge after k. Lane i is bits [9i+8:9i] (lane 0 at the least significant end), and it is written only if bw_n[i], sampled with the command, is low.
- R5: Reads and writes in any mix run on consecutive edges. A read whose address matches a write still waiting for its data returns the arriving din in that write's enabled lanes and the array contents in the other lanes.
- R6: With cen_n high, every synchronous input is ignored and all state, including both pipeline stages, dout and dout_en, holds.
- R7: An accepted edge with adv=1 after a started access issues the next beat of the burst, with the burst's read or write type (we_n is ignored). The beat count wraps modulo 4, so the fifth beat reuses the start address.
- R8: For burst beat n (start beat n=0), address bits [1:0] are (start+n) mod 4 when ilv_order=0 and start XOR n when ilv_order=1. The upper address bits stay those of the start address.
- R9: adv=1 with no access started since reset issues no access.
- R10: If sleep_req is sampled high at edge e, edges e and e+1 work normally and edges from e+2 on are ignored, with dout_en low. Once sleep_req is sampled low at edge a, edges a and a+1 are still ignored and edge a+2 works. Memory, pending writes and burst state survive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low |
| adv | input | 1 | 0: load new address; 1: continue burst |
| we_n | input | 1 | Write enable, active low (new accesses only) |
| bw_n | input | 4 | Byte-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, unregistered |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_req | input | 1 | Sleep request, active high |
| addr | input | AW | Word address |
| din | input | 36 | Write data, four 9-bit lanes |
| dout | output | 36 | Registered read data |
| dout_en | output | 1 | High when dout should be driven onto the bus |

## Verification
The assertions assume that reset is held across the first edge and that every control input is at a known level at each edge. Under those assumptions, pipeline advance, stall holding, burst stepping and sleep entry can be stated as relations between one edge and the next. The bench changes every input one nanosecond after the rising edge, and it changes oe_n and sleep_req only at those points or in a directly checked mid-cycle step. Before any read, it writes every word with all lanes, so that no read returns contents the model cannot know.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BURST_BITS = 2;

  // address of beat n within a burst that started at offset start
  function automatic logic [BURST_BITS-1:0] burst_offset(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] n,
    input logic                  interleave
  );
    logic [BURST_BITS-1:0] lin;
    lin = start + n;
    return interleave ? (start ^ n) : lin;
  endfunction
endpackage

// File: rtl/pbs_sleep_ctl.sv
module pbs_sleep_ctl #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  output logic asleep
);
  logic [LAT-1:0] sq;

  always_ff @(posedge clk) begin
    if (rst) sq <= '0;
    else     sq <= {sq[LAT-2:0], sleep_req};
  end

  assign asleep = sq[LAT-1];

  // R10
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !sq[0] && !asleep) |=> !asleep);
endmodule

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          adv,
  input  logic          wr_in,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  output logic          cmd_vld,
  output logic          cmd_wr,
  output logic [AW-1:0] cmd_addr
);
  import pbs_pkg::*;
  localparam int BB = BURST_BITS;

  logic [AW-1:0] base_q;
  logic [BB-1:0] beat_q, beat_nx;
  logic          act_q, wr_q;

  assign beat_nx = beat_q + 1'b1;

  always_comb begin
    if (!adv) begin
      cmd_vld  = 1'b1;
      cmd_wr   = wr_in;
      cmd_addr = addr;
    end else begin
      cmd_vld  = act_q;
      cmd_wr   = wr_q;
      cmd_addr = {base_q[AW-1:BB], burst_offset(base_q[BB-1:0], beat_nx, ilv)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (en) begin
      if (!adv) begin
        base_q <= addr;
        beat_q <= '0;
        act_q  <= 1'b1;
        wr_q   <= wr_in;
      end else if (act_q) begin
        beat_q <= beat_nx;
      end
    end
  end

  // R7
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && adv && act_q) |=> (beat_q == BB'($past(beat_q) + 1'b1)));
  // R7
  burst_load_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !adv) |=> (act_q && beat_q == '0));
endmodule

// File: rtl/pbs_array.sv
module pbs_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                we,
  input  logic [LANES-1:0]    wbe,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] ram [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wbe[g]) ram[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = ram[raddr];
  end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram #(
  parameter int AW        = 6,
  parameter int LANES     = 4,
  parameter int LW        = 9,
  parameter int SLEEP_LAT = 2,
  localparam int DW       = LANES * LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cen_n,
  input  logic             adv,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  input  logic             ilv_order,
  input  logic             sleep_req,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);
  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [AW-1:0]    a;
    logic [LANES-1:0] be;
  } stage_t;

  logic          asleep, en;
  logic          cmd_vld, cmd_wr;
  logic [AW-1:0] cmd_addr;
  stage_t        s1, s2, s1_nx;
  logic [DW-1:0] arr_rd, rd_word;
  logic          fwd_hit, rdv_q;

  assign en = !cen_n && !asleep;

  pbs_sleep_ctl #(.LAT(SLEEP_LAT)) u_sleep (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .asleep(asleep)
  );

  pbs_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .en(en), .adv(adv), .wr_in(!we_n),
    .ilv(ilv_order), .addr(addr),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr)
  );

  assign s1_nx = '{vld: cmd_vld, wr: cmd_wr, a: cmd_addr, be: ~bw_n};

  // stage 2 write retires with the data arriving at this edge
  pbs_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_arr (
    .clk(clk), .we(en && s2.vld && s2.wr), .wbe(s2.be), .waddr(s2.a),
    .wdata(din), .raddr(s1.a), .rdata(arr_rd)
  );

  assign fwd_hit = s2.vld && s2.wr && (s2.a == s1.a);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign rd_word[g*LW +: LW] = (fwd_hit && s2.be[g]) ? din[g*LW +: LW]
                                                       : arr_rd[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= '0;
      s2    <= '0;
      rdv_q <= 1'b0;
      dout  <= '0;
    end else if (en) begin
      s1 <= s1_nx;
      s2 <= s1;
      if (s1.vld && !s1.wr) begin
        dout  <= rd_word;
        rdv_q <= 1'b1;
      end else begin
        rdv_q <= 1'b0;
      end
    end
  end

  assign dout_en = rdv_q && !oe_n && !asleep;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> ($stable(s1) && $stable(s2) && $stable(dout) && $stable(rdv_q)));
  // R4
  wr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (en && s1.vld && s1.wr) |=> (s2.vld && s2.wr && s2.a == $past(s1.a)));
  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (en && s1.vld && !s1.wr) |=> rdv_q);
endmodule

// File: tb/pipe_burst_sram_tb.sv
`timescale 1ns/1ps
module pipe_burst_sram_tb;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, cen_n, adv, we_n, oe_n, ilv_order, sleep_req;
  logic [3:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en;

  always #2 clk = ~clk;

  pipe_burst_sram #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cen_n(cen_n), .adv(adv), .we_n(we_n), .bw_n(bw_n),
    .oe_n(oe_n), .ilv_order(ilv_order), .sleep_req(sleep_req), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";
  logic [31:0] rs = 32'h1234_5678;

  // bench model state
  logic [DW-1:0] mem_m [DEPTH];
  logic m_q0, m_q1, m_act, m_wr, m_rdv;
  logic [1:0] m_beat;
  logic [AW-1:0] m_base;
  logic [DW-1:0] m_dout;
  logic p1v, p1w, p2v, p2w;
  logic [AW-1:0] p1a, p2a;
  logic [3:0] p1b, p2b;

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_q0 = 0; m_q1 = 0; m_act = 0; m_wr = 0; m_rdv = 0; m_beat = 0; m_base = '0;
    m_dout = '0; p1v = 0; p1w = 0; p2v = 0; p2w = 0; p1a = '0; p2a = '0; p1b = '0; p2b = '0;
  endtask

  task automatic m_edge();
    logic en, cv, cw;
    logic [AW-1:0] ca;
    logic [DW-1:0] rd;
    en = !cen_n && !m_q1;
    m_q1 = m_q0;
    m_q0 = sleep_req;
    if (en) begin
      cv = 0; cw = 0; ca = '0;
      if (!adv) begin
        cv = 1; cw = !we_n; ca = addr;
        m_base = addr; m_beat = 0; m_act = 1; m_wr = !we_n;
      end else if (m_act) begin
        m_beat = m_beat + 2'd1;
        cv = 1; cw = m_wr;
        ca = {m_base[AW-1:2], ilv_order ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
      end
      if (p1v && !p1w) begin
        rd = mem_m[p1a];
        if (p2v && p2w && p2a == p1a)
          for (int i = 0; i < 4; i++) if (p2b[i]) rd[i*9 +: 9] = din[i*9 +: 9];
        m_dout = rd;
        m_rdv = 1;
      end else begin
        m_rdv = 0;
      end
      if (p2v && p2w)
        for (int i = 0; i < 4; i++) if (p2b[i]) mem_m[p2a][i*9 +: 9] = din[i*9 +: 9];
      p2v = p1v; p2w = p1w; p2a = p1a; p2b = p1b;
      p1v = cv; p1w = cw; p1a = ca; p1b = ~bw_n;
    end
  endtask

  task automatic step(input logic c, input logic a, input logic w, input logic [3:0] b,
                      input logic [AW-1:0] ad, input logic o, input logic il, input logic sl);
    logic [31:0] r;
    cen_n = c; adv = a; we_n = w; bw_n = b; addr = ad; oe_n = o; ilv_order = il; sleep_req = sl;
    r = rnd();
    din = {r[7:4], rnd()};
    @(posedge clk);
    #1;
    m_edge();
    chk(dout_en === (m_rdv && !oe_n && !m_q1), "dout_en", {35'd0, dout_en},
        {35'd0, (m_rdv && !oe_n && !m_q1)});
    chk(dout === m_dout, "dout", dout, m_dout);
  endtask

  task automatic rnd_step(input int cen_thr, input bit oe_rand, input logic sl);
    logic [31:0] r;
    r = rnd();
    step(r[3:0] < cen_thr[3:0], r[4] & r[5], r[6], r[10:7],
         r[21] ? {3'b000, r[13:11]} : r[26:21], oe_rand ? (r[14] & r[15]) : 1'b0, r[16], sl);
  endtask

  task automatic sweep_read();
    for (int a = 0; a < DEPTH; a++) step(0, 0, 1, 4'h0, AW'(a), 0, 0, 0);
    step(0, 0, 1, 4'h0, '0, 0, 0, 0);
  endtask

  initial begin
    logic sl;
    rst = 1; cen_n = 0; adv = 1; we_n = 1; bw_n = '0; oe_n = 0; ilv_order = 0;
    sleep_req = 0; addr = '0; din = '0;
    for (int a = 0; a < DEPTH; a++) mem_m[a] = '0;
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    tag = "R1";
    chk(dout === '0, "dout after reset", dout, '0);
    chk(dout_en === 1'b0, "dout_en after reset", {35'd0, dout_en}, '0);

    tag = "R9";
    repeat (3) step(0, 1, 0, 4'h0, 6'd5, 0, 0, 0);

    tag = "R4";
    for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 4'h0, AW'(a), 0, 0, 0);
    tag = "R2";
    sweep_read();

    tag = "R3";
    oe_n = 1; #1;
    chk(dout_en === 1'b0, "dout_en with oe_n high", {35'd0, dout_en}, '0);
    oe_n = 0; #1;
    chk(dout_en === m_rdv, "dout_en with oe_n low", {35'd0, dout_en}, {35'd0, m_rdv});

    tag = "R5";
    for (int m = 0; m < 16; m++) begin
      step(0, 0, 0, ~4'(m), AW'(m * 4 + 1), 0, 0, 0);
      step(0, 0, 1, 4'h0, AW'(m * 4 + 1), 0, 0, 0);
      step(0, 0, 1, 4'h0, AW'(m * 4 + 1), 0, 0, 0);
    end

    for (int il = 0; il < 2; il++) begin
      tag = (il == 0) ? "R7" : "R8";
      for (int s = 0; s < 4; s++) begin
        for (int wr = 0; wr < 2; wr++) begin
          step(0, 0, wr[0] ? 1'b0 : 1'b1, 4'h0, AW'(16 + s), 0, il[0], 0);
          for (int n = 0; n < 6; n++) step(0, 1, ~wr[0], 4'h0, 6'd0, 0, il[0], 0);
        end
      end
      sweep_read();
    end

    tag = "R6";
    repeat (400) rnd_step(4, 0, 0);
    sweep_read();

    tag = "R3";
    repeat (200) rnd_step(0, 1, 0);

    tag = "R10";
    sl = 0;
    for (int k = 0; k < 400; k++) begin
      if (rnd() % 12 == 0) sl = ~sl;
      rnd_step(2, 0, sl);
    end
    repeat (3) step(0, 0, 1, 4'h0, 6'd0, 0, 0, 0);
    sweep_read();

    tag = "R5";
    repeat (2000) rnd_step(2, 1, 0);
    sweep_read();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule